// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a synthesizable, single-clock stand-in for an asynchronous 16-bit-wide static memory that has two independently selectable byte lanes. A controller under test drives active-low chip select, output enable, write enable and one select per byte lane, together with a word address and write data. On each rising clock edge the model samples these inputs and decides which lanes, if any, it stores and which it drives. The tri-state data pins become a plain read-data bus plus a per-lane drive-enable pair, so a bench or formal checker can see exactly when each lane would leave high impedance.

The word address width is a parameter. Set it to 15 to get the full 32,768-word part. The default is smaller, which keeps elaboration light. Memory contents are never reset. A lane that is not written in a cycle keeps its stored byte. All outputs are registered, so every sampled command shows its effect one clock later.

Top module: `sram_lane_model`

## Requirements
- R1: While reset is asserted and directly after it, `lane_drv` is 2'b00 and `rd_data` is zero.
- R2: A cycle sampled with `chip_sel_n` high leaves both lanes undriven in the next cycle and changes no stored byte, whatever the other controls are.
- R3: With `chip_sel_n` low and `wr_en_n` high, a high `out_en_n` leaves both lanes undriven in the next cycle.
- R4: With `chip_sel_n` low and both `lo_sel_n` and `hi_sel_n` high, neither lane is driven in the next cycle and no byte is stored.
- R5: A read (`chip_sel_n` low, `wr_en_n` high, `out_en_n` low) drives the lower lane (`lane_drv[0]`, data bits 7:0) only if `lo_sel_n` is low, and the upper lane (`lane_drv[1]`, bits 15:8) only if `hi_sel_n` is low. Each driven lane carries the byte stored at `addr`.
- R6: A write (`chip_sel_n` low, `wr_en_n` low) stores `wr_data` bits 7:0 when `lo_sel_n` is low and bits 15:8 when `hi_sel_n` is low. `out_en_n` has no effect on a write.
- R7: The cycle after a sampled write, both lanes are undriven.
- R8: A lane whose select is high during a write keeps its earlier byte at that address.
- R9: An undriven lane reads as zero on `rd_data`.
- R10: Read results and drive enables appear exactly one clock after the edge that samples the command. Back-to-back reads of different addresses each return their own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset of the output registers |
| addr | input | ADDR_W | Word address |
| wr_data | input | 16 | Write data, bits 15:8 upper lane, 7:0 lower lane |
| chip_sel_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| lo_sel_n | input | 1 | Active-low lower-lane select |
| hi_sel_n | input | 1 | Active-low upper-lane select |
| rd_data | output | 16 | Registered read data, zero on undriven lanes |
| lane_drv | output | 2 | Registered drive enable per lane, bit 0 lower, bit 1 upper |

## Verification
Full-word writes of distinct patterns to low, middle and top addresses, followed by full reads, show that addressing and storage are correct. Single-lane reads show that each byte select gates only its own half. Single-lane writes, followed by full reads, separate an updated lane from a preserved one, and switching output enable during writes shows that it has no effect there. Deselected writes, writes with both selects high, and reads with output enable high each try to store or drive under a combination that must float. The reads after them then prove that no byte changed.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;

    typedef struct packed {
        logic              drv;
        logic [LANE_W-1:0] dat;
    } lane_out_t;
endpackage

// File: rtl/sram_ctl_decode.sv
module sram_ctl_decode #(
    parameter int LANES = 2
) (
    input  logic             chip_sel_n,
    input  logic             out_en_n,
    input  logic             wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] wr_lane,
    output logic [LANES-1:0] rd_lane
);
    logic selected;
    logic is_write;
    logic is_read;

    always_comb begin
        selected = !chip_sel_n;
        is_write = selected && !wr_en_n;
        is_read  = selected && wr_en_n && !out_en_n;
        for (int i = 0; i < LANES; i++) begin
            wr_lane[i] = is_write && !lane_sel_n[i];
            rd_lane[i] = is_read  && !lane_sel_n[i];
        end
    end

    // A lane is never both stored and driven in one cycle.
    always_comb begin
        assert_rd_wr_exclusive_R7: assert ((wr_lane & rd_lane) == '0);
    end
endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [LANE_W-1:0] wdata,
    output logic              drv,
    output logic [LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];
    lane_out_t out_d, out_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    always_comb begin
        out_d     = out_q;
        out_d.drv = rd_en;
        out_d.dat = rd_en ? mem[addr] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign drv   = out_q.drv;
    assign rdata = out_q.dat;

    assert_lane_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> drv);
    assert_lane_float_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !drv);
    assert_lane_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !drv |-> rdata == '0);
endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic                    chip_sel_n,
    input  logic                    out_en_n,
    input  logic                    wr_en_n,
    input  logic                    lo_sel_n,
    input  logic                    hi_sel_n,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic [LANES-1:0]        lane_drv
);
    logic [LANES-1:0] lane_sel_n;
    logic [LANES-1:0] wr_lane;
    logic [LANES-1:0] rd_lane;

    assign lane_sel_n = {hi_sel_n, lo_sel_n};

    sram_ctl_decode #(.LANES(LANES)) decode_i (
        .chip_sel_n (chip_sel_n),
        .out_en_n   (out_en_n),
        .wr_en_n    (wr_en_n),
        .lane_sel_n (lane_sel_n),
        .wr_lane    (wr_lane),
        .rd_lane    (rd_lane)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_byte_lane #(.ADDR_W(ADDR_W)) lane_i (
            .clk   (clk),
            .rst_n (rst_n),
            .addr  (addr),
            .wr_en (wr_lane[g]),
            .rd_en (rd_lane[g]),
            .wdata (wr_data[g*LANE_W +: LANE_W]),
            .drv   (lane_drv[g]),
            .rdata (rd_data[g*LANE_W +: LANE_W])
        );
    end

    assert_deselect_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chip_sel_n |=> lane_drv == '0);
    assert_oe_high_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_sel_n && wr_en_n && out_en_n) |=> lane_drv == '0);
    assert_no_lane_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_sel_n && lo_sel_n && hi_sel_n) |=> lane_drv == '0);
    assert_write_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_sel_n && !wr_en_n) |=> lane_drv == '0);
endmodule

// File: tb/sram_lane_model_tb.sv
module sram_lane_model_tb_top;
    localparam int ADDR_W = 11;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       wr_data = '0;
    logic              chip_sel_n = 1'b1;
    logic              out_en_n = 1'b1;
    logic              wr_en_n = 1'b1;
    logic              lo_sel_n = 1'b1;
    logic              hi_sel_n = 1'b1;
    logic [15:0]       rd_data;
    logic [1:0]        lane_drv;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    logic [15:0] ref_mem [DEPTH];
    logic [17:0] exp_q [$];
    string       tag_q [$];

    always #4 clk = ~clk;

    sram_lane_model #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .chip_sel_n(chip_sel_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n),
        .lo_sel_n(lo_sel_n), .hi_sel_n(hi_sel_n),
        .rd_data(rd_data), .lane_drv(lane_drv)
    );

    task automatic compare(input logic [17:0] act, input logic [17:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: drv/data got %b/%h expected %b/%h",
                     tag, act[17:16], act[15:0], exp[17:16], exp[15:0]);
        end
    endtask

    // Driver: applies one command and pushes its expected registered result.
    task automatic op(input logic cs, input logic oe, input logic we,
                      input logic lo, input logic hi, input int a,
                      input logic [15:0] wd, input string tag);
        logic [1:0]  drv;
        logic [15:0] dat;
        @(negedge clk);
        chip_sel_n = cs; out_en_n = oe; wr_en_n = we;
        lo_sel_n = lo; hi_sel_n = hi; addr = a[ADDR_W-1:0]; wr_data = wd;
        drv = (!cs && we && !oe) ? {!hi, !lo} : 2'b00;
        dat = 16'h0000;
        if (drv[0]) dat[7:0]  = ref_mem[a][7:0];
        if (drv[1]) dat[15:8] = ref_mem[a][15:8];
        if (!cs && !we) begin
            if (!lo) ref_mem[a][7:0]  = wd[7:0];
            if (!hi) ref_mem[a][15:8] = wd[15:8];
        end
        exp_q.push_back({drv, dat});
        tag_q.push_back(tag);
    endtask

    // Monitor: compares just after the edge that registers each command.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0)
                compare({lane_drv, rd_data}, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare({lane_drv, rd_data}, 18'h0, "R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        #1 compare({lane_drv, rd_data}, 18'h0, "R1 after reset");

        // R6: full-word writes, output enable both ways
        op(0, 0, 0, 0, 0, 0,         16'hA55A, "R6 write oe low");
        op(0, 1, 0, 0, 0, 1,         16'h1234, "R6 write oe high");
        op(0, 0, 0, 0, 0, 2,         16'hFF00, "R7 write no drive");
        op(0, 1, 0, 0, 0, 3,         16'h00FF, "R6 write");
        op(0, 0, 0, 0, 0, 4,         16'hBEEF, "R6 write");
        op(0, 1, 0, 0, 0, 5,         16'hC0DE, "R6 write");
        op(0, 0, 0, 0, 0, DEPTH/2,   16'h5AA5, "R6 write mid");
        op(0, 1, 0, 0, 0, DEPTH-1,   16'h8001, "R6 write top");
        // R5/R10: back-to-back full reads
        for (int i = 0; i < 6; i++) op(0, 0, 1, 0, 0, i, 16'h0, "R10 read");
        op(0, 0, 1, 0, 0, DEPTH/2, 16'h0, "R5 read mid");
        op(0, 0, 1, 0, 0, DEPTH-1, 16'h0, "R5 read top");
        // R5/R9: single-lane reads
        op(0, 0, 1, 0, 1, 0, 16'h0, "R9 read lower only");
        op(0, 0, 1, 1, 0, 0, 16'h0, "R9 read upper only");
        op(0, 0, 1, 1, 0, 4, 16'h0, "R5 read upper only");
        // R6/R8: single-lane writes then full reads
        op(0, 0, 0, 0, 1, 2, 16'h1177, "R8 write lower only");
        op(0, 1, 0, 1, 0, 3, 16'h9922, "R8 write upper only");
        op(0, 0, 1, 0, 0, 2, 16'h0, "R8 read lower-written");
        op(0, 0, 1, 0, 0, 3, 16'h0, "R8 read upper-written");
        // R2: deselected write must not store or drive
        op(1, 0, 0, 0, 0, 4, 16'h0000, "R2 deselected write");
        op(1, 0, 1, 0, 0, 4, 16'h0000, "R2 deselected read");
        op(0, 0, 1, 0, 0, 4, 16'h0, "R2 contents kept");
        // R4: both lane selects high
        op(0, 0, 0, 1, 1, 5, 16'h0000, "R4 write no lanes");
        op(0, 0, 1, 1, 1, 5, 16'h0, "R4 read no lanes");
        op(0, 0, 1, 0, 0, 5, 16'h0, "R4 contents kept");
        // R3: output enable high during read
        op(0, 1, 1, 0, 0, 1, 16'h0, "R3 oe high float");
        op(0, 0, 1, 0, 0, 1, 16'h0, "R3 read after");
        op(1, 1, 1, 1, 1, 0, 16'h0, "R2 idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule